// File: doc/BRIEF.md
# Symmetric FIR Tap Cell

This block is one cascadable slice of a time-multiplexed FIR filter. It holds two 16-deep sample delay lines of 18-bit words. One runs forward, toward the far end of the cascade. The other runs backward, toward the near end. It also holds a 16-word table of 16-bit coefficients. Each clock, a tap index selects one coefficient and one pair of delay-line words. A pre-adder folds the pair into one operand, a multiplier scales that operand by the coefficient, and the product is added to a 38-bit partial sum arriving from the neighbouring cell.

In symmetric mode the pre-adder adds the forward word of age t to the backward word of age 15−t. One multiply then covers two taps, so sixteen cells cover 32 taps per clock. To keep that sum inside 18 bits, samples stored while symmetric mode is on are saturated to a 17-bit range. In plain mode the backward word is ignored and samples are stored unchanged.

Both the product and the chain addition are registered. Each cell therefore adds one cycle of latency along the chain. The oldest word of each delay line is presented combinationally so the next cell in that direction can take it in.

Top module: `symfir_tap_cell`

## Requirements
- R1: Synchronous active-low reset. On the first falling clock edge after reset, chain_out, sample_out and bwd_out are all zero, and every delay-line word and coefficient word reads as zero.
- R2: When coef_we is high at a rising edge, coef_data is stored at coef_addr. A tap read in the same cycle still uses the old word, and reads from the next cycle on use the new one.
- R3: A rising edge with shift_en high stores the forward input as the age-0 word of the forward line and advances every older word by one age. sample_out shows the age-15 word, which is the sample stored 15 shifts before the most recent one. Without shift_en, the line and sample_out hold.
- R4: The backward line behaves the same way. It is fed from bwd_in, shifts on the same shift_en, and shows its age-15 word on bwd_out.
- R5: At tap index t the operand is the 18-bit wrapped sum of forward age t and backward age 15−t when sym_en is high. When sym_en is low the operand is forward age t alone, and the backward contents have no effect on chain_out.
- R6: While sym_en is high, each sample written into either line is saturated to the signed range −65536..65535 (18'h30000..18'h0FFFF). While sym_en is low, samples are stored with all 18 bits unchanged.
- R7: The operand and coefficient presented before rising edge k are multiplied as signed values and registered at edge k. At edge k+1, chain_out becomes chain_in, as sampled at edge k+1, plus that product sign-extended.
- R8: The chain addition is 38-bit two's complement and wraps modulo 2^38 with no saturation.
- R9: tap_idx (4 bits, 0..15) selects coefficient word t, forward age t and backward age 15−t in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_en | input | 1 | Symmetric mode: fold the backward line in and saturate stored samples |
| shift_en | input | 1 | Advance both delay lines by one sample |
| sample_in | input | 18 | New sample entering the forward line |
| bwd_in | input | 18 | Sample entering the backward line from the next cell |
| tap_idx | input | 4 | Tap index for this cycle |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient write address |
| coef_data | input | 16 | Coefficient write data, signed |
| chain_in | input | 38 | Partial sum from the neighbouring cell |
| chain_out | output | 38 | Registered partial sum toward the first cell |
| sample_out | output | 18 | Oldest forward word, handed to the next cell |
| bwd_out | output | 18 | Oldest backward word, handed to the previous cell |

## Verification
chain_out is due two rising edges after the tap index and coefficient that produced its product, and one rising edge after the chain_in it adds. sample_out and bwd_out change right after the rising edge that shifts. The driver applies inputs just after each falling edge and pushes the result expected after the coming rising edge, built by pairing this cycle's chain_in with the product it predicted one cycle earlier. The monitor pops and compares that entry at the next falling edge, half a period after the edge on which the result is due.

// File: rtl/symfir_pkg.sv
// Shared constants for the symmetric FIR tap cell.
// Assumes: the delay-line depth is a power of two so address arithmetic wraps.
package symfir_pkg;
    localparam int LINE_FWD      = 0;   // index of the forward delay line
    localparam int LINE_BWD      = 1;   // index of the backward delay line
    localparam int NUM_LINES     = 2;
    localparam int DEF_DATA_W    = 18;
    localparam int DEF_COEF_W    = 16;
    localparam int DEF_SUM_W     = 38;
    localparam int DEF_TAPS      = 16;
endpackage

// File: rtl/symfir_delay_line.sv
// Circular sample delay line. A shift writes the new word at the head slot and
// moves the head on, so every stored word ages by one. Reads are by age
// (0 = newest). The oldest word sits at the head slot that the next shift overwrites.
// Assumes: DEPTH is a power of two.
module symfir_delay_line #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_age,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] oldest,
    output logic [DATA_W-1:0] newest
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     head;
    logic [AW-1:0]     rd_slot;

    // Storage and head pointer: clear on reset, write and advance on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (shift_en) begin
            mem[head] <= wr_data;
            head      <= head + AW'(1);
        end
    end

    // Age-to-slot mapping: the newest word lives one slot behind the head.
    always_comb begin
        rd_slot = head - AW'(1) - rd_age;
        rd_data = mem[rd_slot];
        oldest  = mem[head];
        newest  = mem[head - AW'(1)];
    end

    // R3 / R4: a shift advances the head by exactly one slot
    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> head == $past(head) + AW'(1));

    // R3 / R4: the written sample becomes the age-0 word
    a_r3_write: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> newest == $past(wr_data));

    // R3 / R4: without a shift the line holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(head) && $stable(oldest) && $stable(newest));
endmodule

// File: rtl/symfir_coef_mem.sv
// Coefficient table: one write port, one combinational read port.
// A write lands at the rising edge, so a read in the same cycle returns the old word.
// Assumes: DEPTH is a power of two.
module symfir_coef_mem #(
    parameter int COEF_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [COEF_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [COEF_W-1:0] rd_data
);
    logic [COEF_W-1:0] mem [DEPTH];

    // Coefficient storage: clear on reset, store on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read port: combinational lookup by tap index.
    assign rd_data = mem[rd_addr];

    // R2: a strobed write is held at its address afterwards
    a_r2_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/symfir_mac.sv
// Pre-adder, multiplier and sum-chain stage. The backward operand is gated by
// fold_en, added to the forward operand in DATA_W bits, multiplied by the signed
// coefficient and registered. One cycle later the product, sign-extended, is
// added to the incoming partial sum and registered again.
// Assumes: the caller has limited the operands when folding, so that the sum fits.
module symfir_mac #(
    parameter int DATA_W = 18,
    parameter int COEF_W = 16,
    parameter int SUM_W  = 38,
    localparam int PROD_W = DATA_W + COEF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fold_en,
    input  logic [DATA_W-1:0] fwd_word,
    input  logic [DATA_W-1:0] bwd_word,
    input  logic [COEF_W-1:0] coef,
    input  logic [SUM_W-1:0]  chain_in,
    output logic [SUM_W-1:0]  chain_out
);
    logic [DATA_W-1:0]        bwd_gated;
    logic [DATA_W-1:0]        pre_sum;
    logic signed [PROD_W-1:0] prod_c;
    logic signed [PROD_W-1:0] prod_q;

    // Pre-adder and multiplier: fold the two taps, then scale by the coefficient.
    always_comb begin
        bwd_gated = fold_en ? bwd_word : '0;
        pre_sum   = fwd_word + bwd_gated;
        prod_c    = $signed(coef) * $signed(pre_sum);
    end

    // Two pipeline registers: the product, then the chain sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q    <= '0;
            chain_out <= '0;
        end else begin
            prod_q    <= prod_c;
            chain_out <= chain_in + SUM_W'(prod_q);
        end
    end

    // Checker-side reference, evaluated at full chain width.
    logic [1:0]              chk_warm;
    logic [DATA_W-1:0]       chk_fold;
    logic signed [SUM_W-1:0] chk_term;

    // Warm-up counter: counts cycles since reset, so $past never reaches into reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_warm <= '0;
        end else if (chk_warm != 2'd2) begin
            chk_warm <= chk_warm + 2'd1;
        end
    end

    // Reference term: the folded operand times the coefficient, both widened to SUM_W.
    always_comb begin
        chk_fold = fwd_word + (fold_en ? bwd_word : {DATA_W{1'b0}});
        chk_term = SUM_W'($signed(coef)) * SUM_W'($signed(chk_fold));
    end

    // R5 / R7 / R8: chain_out = chain_in one edge back + folded product two edges back
    a_r7_chain_timing: assert property (@(posedge clk) disable iff (!rst_n)
        chk_warm == 2'd2 |-> chain_out == $past(chain_in) + $past(chk_term, 2));
endmodule

// File: rtl/symfir_tap_cell.sv
// One cell of a time-multiplexed symmetric FIR cascade. It holds the forward and
// backward sample delay lines and the coefficient table, saturates incoming
// samples in symmetric mode, and passes the selected taps to the MAC stage.
// The oldest word of each line is presented combinationally for the next cell
// in that direction.
// Assumes: TAPS is a power of two; tap_idx is driven every cycle.
module symfir_tap_cell
    import symfir_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int SUM_W  = DEF_SUM_W,
    parameter int TAPS   = DEF_TAPS,
    localparam int AW    = $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_en,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] sample_in,
    input  logic [DATA_W-1:0] bwd_in,
    input  logic [AW-1:0]     tap_idx,
    input  logic              coef_we,
    input  logic [AW-1:0]     coef_addr,
    input  logic [COEF_W-1:0] coef_data,
    input  logic [SUM_W-1:0]  chain_in,
    output logic [SUM_W-1:0]  chain_out,
    output logic [DATA_W-1:0] sample_out,
    output logic [DATA_W-1:0] bwd_out
);
    localparam int LIM_HI = (1 << (DATA_W - 2)) - 1;
    localparam int LIM_LO = -(1 << (DATA_W - 2));

    logic [DATA_W-1:0] line_raw [NUM_LINES];
    logic [DATA_W-1:0] line_wr  [NUM_LINES];
    logic [AW-1:0]     line_age [NUM_LINES];
    logic [DATA_W-1:0] line_rd  [NUM_LINES];
    logic [DATA_W-1:0] line_old [NUM_LINES];
    logic [DATA_W-1:0] line_new [NUM_LINES];
    logic [COEF_W-1:0] coef_rd;

    // Line inputs and read ages: forward reads age t, backward reads the mirror age.
    always_comb begin
        line_raw[LINE_FWD] = sample_in;
        line_raw[LINE_BWD] = bwd_in;
        line_age[LINE_FWD] = tap_idx;
        line_age[LINE_BWD] = AW'(TAPS - 1) - tap_idx;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic top_bits_agree;

        // Input limiter: saturate to one bit less of range when folding.
        always_comb begin
            top_bits_agree = line_raw[g][DATA_W-1] == line_raw[g][DATA_W-2];
            if (sym_en && !top_bits_agree) begin
                line_wr[g] = {{2{line_raw[g][DATA_W-1]}}, {(DATA_W-2){~line_raw[g][DATA_W-1]}}};
            end else begin
                line_wr[g] = line_raw[g];
            end
        end

        symfir_delay_line #(
            .DATA_W (DATA_W),
            .DEPTH  (TAPS)
        ) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .wr_data  (line_wr[g]),
            .rd_age   (line_age[g]),
            .rd_data  (line_rd[g]),
            .oldest   (line_old[g]),
            .newest   (line_new[g])
        );

        // R6: in symmetric mode every stored sample lies inside the 17-bit range
        a_r6_limited: assert property (@(posedge clk) disable iff (!rst_n)
            (shift_en && sym_en) |=>
                ($signed(line_new[g]) <= DATA_W'(LIM_HI)) &&
                ($signed(line_new[g]) >= DATA_W'(LIM_LO)));

        // R6: in plain mode the sample is stored unchanged
        a_r6_plain_exact: assert property (@(posedge clk) disable iff (!rst_n)
            (shift_en && !sym_en) |=> line_new[g] == $past(line_raw[g]));
    end

    symfir_coef_mem #(
        .COEF_W (COEF_W),
        .DEPTH  (TAPS)
    ) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_we),
        .wr_addr (coef_addr),
        .wr_data (coef_data),
        .rd_addr (tap_idx),
        .rd_data (coef_rd)
    );

    symfir_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .SUM_W  (SUM_W)
    ) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .fold_en   (sym_en),
        .fwd_word  (line_rd[LINE_FWD]),
        .bwd_word  (line_rd[LINE_BWD]),
        .coef      (coef_rd),
        .chain_in  (chain_in),
        .chain_out (chain_out)
    );

    // Cascade outputs: the oldest word of each line goes to its neighbour.
    assign sample_out = line_old[LINE_FWD];
    assign bwd_out    = line_old[LINE_BWD];

    // R1: all outputs are zero on the first cycle after reset
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> chain_out == '0 && sample_out == '0 && bwd_out == '0);
endmodule

// File: tb/symfir_tap_cell_test.sv
// Scoreboard bench: the driver predicts each cycle's outputs from a model built
// on the requirements and queues them; the monitor compares at falling edges.
module symfir_tap_cell_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_en = 1'b0, shift_en = 1'b0, coef_we = 1'b0;
    logic [17:0] sample_in = '0, bwd_in = '0;
    logic [3:0]  tap_idx = '0, coef_addr = '0;
    logic [15:0] coef_data = '0;
    logic [37:0] chain_in = '0;
    logic [37:0] chain_out;
    logic [17:0] sample_out, bwd_out;

    symfir_tap_cell uut (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .shift_en(shift_en),
        .sample_in(sample_in), .bwd_in(bwd_in), .tap_idx(tap_idx),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .chain_in(chain_in), .chain_out(chain_out),
        .sample_out(sample_out), .bwd_out(bwd_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [37:0] chain;
        logic [17:0] fwd_old;
        logic [17:0] bwd_old;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    // Model state, indexed by age (0 = newest).
    logic [17:0] mf [16];
    logic [17:0] mb [16];
    logic [15:0] mc [16];
    longint      prod_prev = 0;

    function automatic logic [17:0] limit17(input logic [17:0] v, input logic sym);
        int sv;
        sv = int'($signed(v));
        if (!sym) return v;
        if (sv > 65535) return 18'h0FFFF;
        if (sv < -65536) return 18'h30000;
        return v;
    endfunction

    // Driver: apply one cycle of stimulus and queue the outputs due after its rising edge.
    task automatic cyc(input logic sh, input logic [17:0] s, input logic [17:0] b,
                       input logic [3:0] t, input logic [37:0] ci, input logic sym,
                       input logic we, input logic [3:0] wa, input logic [15:0] wd,
                       input string req);
        logic [17:0] pre;
        longint      prod;
        exp_t        e;
        @(negedge clk);
        #1;
        shift_en = sh; sample_in = s; bwd_in = b; tap_idx = t; chain_in = ci;
        sym_en = sym; coef_we = we; coef_addr = wa; coef_data = wd;
        pre  = mf[t] + (sym ? mb[4'd15 - t] : 18'd0);
        prod = longint'($signed(mc[t])) * longint'($signed(pre));
        e.chain = ci + 38'(prod_prev);
        prod_prev = prod;
        if (sh) begin
            for (int i = 15; i > 0; i--) begin
                mf[i] = mf[i-1];
                mb[i] = mb[i-1];
            end
            mf[0] = limit17(s, sym);
            mb[0] = limit17(b, sym);
        end
        if (we) mc[wa] = wd;
        e.fwd_old = mf[15];
        e.bwd_old = mb[15];
        e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compare the oldest queued prediction at each falling edge.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0 && !done) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (chain_out !== e.chain || sample_out !== e.fwd_old || bwd_out !== e.bwd_old) begin
                bad++;
                $display("FAIL %s: chain_out=%h sample_out=%h bwd_out=%h expected %h %h %h",
                         e.req, chain_out, sample_out, bwd_out, e.chain, e.fwd_old, e.bwd_old);
            end
        end
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mf[i] = '0; mb[i] = '0; mc[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: zero state after reset
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        cyc(0, 0, 0, 5, 0, 1, 0, 0, 0, "R1");

        // R2: coefficient load, including both extremes
        for (int i = 0; i < 16; i++) begin
            logic [15:0] c;
            c = (i == 0) ? 16'h8000 : (i == 15) ? 16'h7FFF : 16'(i * 1237 - 9000);
            cyc(0, 0, 0, 4'(i), 38'(i), 0, 1, 4'(i), c, "R2");
        end

        // R3 R4 R7: plain mode fill, both lines shifting, taps rotating
        for (int i = 0; i < 20; i++) begin
            cyc(1, 18'((i * 40503 + 17)), 18'((i * 9973 + 5)), 4'(i), 38'(i * 1000),
                0, 0, 0, 0, "R3 R4 R7");
        end

        // R5 R9: plain-mode tap sweep, backward line must not matter; lines hold
        for (int i = 0; i < 16; i++) begin
            cyc(0, 18'h2AAAA, 18'h15555, 4'(i), 38'(i * 77), 0, 0, 0, 0, "R5 R9 R3");
        end

        // R6 R4: symmetric fill with out-of-range extremes that must saturate
        for (int i = 0; i < 16; i++) begin
            logic [17:0] s, b;
            case (i % 4)
                0: begin s = 18'h1FFFF; b = 18'h20000; end
                1: begin s = 18'h20000; b = 18'h1FFFF; end
                2: begin s = 18'h3FFFF; b = 18'h0FFFF; end
                default: begin s = 18'((i * 3001) & 32'hFFFF); b = 18'h30000; end
            endcase
            cyc(1, s, b, 4'(i), 38'(i), 1, 0, 0, 0, "R6 R4");
        end

        // R5 R9 R7 R2: symmetric sweep; rewrite next tap's coefficient on the way
        for (int i = 0; i < 16; i++) begin
            cyc(0, 0, 0, 4'(i), 38'(i * 31), 1, 1, 4'((i + 1) % 16), 16'(i * 2003 + 11),
                "R5 R9 R7 R2");
        end

        // R8: chain at maximum positive value must wrap on positive products
        for (int i = 0; i < 16; i++) begin
            cyc(0, 0, 0, 4'(i), 38'h1F_FFFF_FFFF, 1, 0, 0, 0, "R8");
        end

        // R3: lines advance again in plain mode after the symmetric phase
        for (int i = 0; i < 8; i++) begin
            cyc(1, 18'(i * 5 + 3), 18'(i * 9 + 1), 4'(15 - i), 38'h20_0000_0000, 0, 0, 0, 0, "R3 R8");
        end

        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule